// File: doc/BRIEF.md
# Masked Packed Test-Nand Unit

This block turns two vector operands into a predicate mask. The operands are split into 64-bit lanes. For each lane the unit ANDs the two operand lanes together. It then sets that lane's result bit when the AND has no bit set. The result is one 8-bit mask with one bit per possible lane. It is meant to sit at the end of a vector execution pipe. There it feeds a predicate register file.

Three controls shape the result:

- A 2-bit length select sets how many lanes are active: 2, 4 or 8.
- A write-mask, with its own enable, zeroes lanes that are switched off. With the enable low, every active lane is computed.
- A broadcast flag repeats the low 64 bits of the second operand across all lanes.

Lanes that are off or outside the active length always read 0. Their operand bits have no influence on the result.

The result is registered in the output controller. This is a two-state machine:

- ST_IDLE: no fresh result is on the output.
- ST_SHOW: a fresh result is on the output, and out_valid is high.

Its transitions are:

- ST_IDLE → ST_SHOW on in_valid.
- ST_SHOW → ST_SHOW on another in_valid, for back-to-back issue.
- ST_SHOW → ST_IDLE when in_valid is low.
- ST_IDLE → ST_IDLE when in_valid is low.

Reset forces ST_IDLE.

Top module: `vtn_mask_unit`

## Requirements
- R1: For each enabled active lane i, out_mask[i] is 1 exactly when (opa[64i+63:64i] & operand-B lane i) equals zero.
- R2: When mask_en is 1 and wmask[i] is 0, out_mask[i] is 0 whatever the operand data.
- R3: When mask_en is 0, the wmask input has no effect and every active lane is tested.
- R4: len_sel 2'b00 activates lanes 0..1, 2'b01 activates lanes 0..3, and 2'b10 activates lanes 0..7. Mask bits above the active lanes are 0.
- R5: len_sel 2'b11 is reserved and gives out_mask equal to 8'h00.
- R6: When bcast is 1, operand-B lane i is opb[63:0] for every lane, and opb[511:64] has no effect. When bcast is 0, operand-B lane i is opb[64i+63:64i].
- R7: Operand bits of lanes above the active length have no effect on out_mask.
- R8: Inputs are captured on a rising edge with in_valid high. out_valid is high, with the matching out_mask, during the following cycle only, unless in_valid is high again.
- R9: While out_valid is low, out_mask holds the last result.
- R10: A synchronous active-high rst clears out_valid and out_mask to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls present this cycle |
| len_sel | input | 2 | Vector length: 00=128, 01=256, 10=512, 11 reserved |
| mask_en | input | 1 | 1 = masked form using wmask, 0 = unmasked form |
| wmask | input | 8 | Per-lane write-mask |
| bcast | input | 1 | 1 = repeat opb[63:0] across all lanes |
| opa | input | 512 | First vector operand |
| opb | input | 512 | Second vector operand |
| out_valid | output | 1 | Result mask valid this cycle |
| out_mask | output | 8 | Per-lane test-nand result |

## Verification
Each result appears one rising edge after the edge that captured its inputs. The driver applies stimulus at a falling edge and pushes the expected mask onto a queue. The monitor samples one time unit after each rising edge. For every cycle it expects out_valid to equal the in_valid seen at that edge, and it pops and compares a mask whenever out_valid is high. In idle cycles the monitor checks that out_mask still equals the last result, and it checks that reset leaves both outputs at zero.

// File: rtl/vtn_pkg.sv
package vtn_pkg;
    parameter int LANE_W    = 64;
    parameter int MAX_LANES = 8;
    localparam int VEC_W    = LANE_W * MAX_LANES;

    typedef enum logic [1:0] {
        LEN_128  = 2'b00,
        LEN_256  = 2'b01,
        LEN_512  = 2'b10,
        LEN_RSVD = 2'b11
    } len_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } out_state_e;
endpackage

// File: rtl/vtn_lane_enable.sv
module vtn_lane_enable
    import vtn_pkg::*;
#(
    parameter int N_LANES = MAX_LANES
) (
    input  logic [1:0]         len_sel,
    input  logic               mask_en,
    input  logic [N_LANES-1:0] wmask,
    output logic [N_LANES-1:0] lane_en
);
    localparam int CNT_W = $clog2(N_LANES + 1);

    logic [CNT_W-1:0]   active_cnt;
    logic [N_LANES-1:0] in_len;
    logic [N_LANES-1:0] wm_eff;

    // Active lane count from the length code; the reserved code enables nothing.
    always_comb begin
        unique case (len_sel)
            LEN_128:  active_cnt = CNT_W'(2);
            LEN_256:  active_cnt = CNT_W'(4);
            LEN_512:  active_cnt = CNT_W'(8);
            default:  active_cnt = '0;
        endcase
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_len
        assign in_len[g] = (CNT_W'(g) < active_cnt);
    end

    // Unmasked form behaves as an all-ones write-mask.
    assign wm_eff  = mask_en ? wmask : '1;
    assign lane_en = in_len & wm_eff;
endmodule

// File: rtl/vtn_lane_test.sv
module vtn_lane_test
    import vtn_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         en,
    output logic         hit
);
    logic [W-1:0] a_g;
    logic [W-1:0] b_g;

    // Gate operands first so a disabled lane's data never reaches the reduction.
    assign a_g = en ? a : '0;
    assign b_g = en ? b : '0;
    assign hit = en & ~(|(a_g & b_g));
endmodule

// File: rtl/vtn_out_ctrl.sv
module vtn_out_ctrl
    import vtn_pkg::*;
#(
    parameter int N_LANES = MAX_LANES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [N_LANES-1:0] mask_next,
    output logic               out_valid,
    output logic [N_LANES-1:0] out_mask
);
    out_state_e state_q;
    out_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           out_mask <= '0;
        else if (in_valid) out_mask <= mask_next;
    end

    assign out_valid = (state_q == ST_SHOW);
endmodule

// File: rtl/vtn_mask_unit.sv
module vtn_mask_unit
    import vtn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       len_sel,
    input  logic             mask_en,
    input  logic [7:0]       wmask,
    input  logic             bcast,
    input  logic [511:0]     opa,
    input  logic [511:0]     opb,
    output logic             out_valid,
    output logic [7:0]       out_mask
);
    localparam int NL = MAX_LANES;
    localparam int LW = LANE_W;

    logic [NL-1:0] lane_en;
    logic [NL-1:0] lane_hit;

    vtn_lane_enable #(.N_LANES(NL)) u_en (
        .len_sel (len_sel),
        .mask_en (mask_en),
        .wmask   (wmask),
        .lane_en (lane_en)
    );

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] b_sel;
        assign b_sel = bcast ? opb[LW-1:0] : opb[g*LW +: LW];

        vtn_lane_test #(.W(LW)) u_test (
            .a   (opa[g*LW +: LW]),
            .b   (b_sel),
            .en  (lane_en[g]),
            .hit (lane_hit[g])
        );
    end

    vtn_out_ctrl #(.N_LANES(NL)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mask_next (lane_hit),
        .out_valid (out_valid),
        .out_mask  (out_mask)
    );
endmodule

// File: rtl/vtn_mask_unit_chk.sv
module vtn_mask_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   len_sel,
    input logic         mask_en,
    input logic [7:0]   wmask,
    input logic         bcast,
    input logic [511:0] opa,
    input logic [511:0] opb,
    input logic         out_valid,
    input logic [7:0]   out_mask
);
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drops_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_mask));

    p_wmask_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en) |=> ((out_mask & ~$past(wmask)) == 8'h00));

    p_len128_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && len_sel == 2'b00) |=> (out_mask[7:2] == 6'h00));

    p_len256_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && len_sel == 2'b01) |=> (out_mask[7:4] == 4'h0));

    p_reserved_len_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && len_sel == 2'b11) |=> (out_mask == 8'h00));

    p_lane0_disjoint_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && len_sel != 2'b11 && (!mask_en || wmask[0])
         && ((opa[63:0] & opb[63:0]) == 64'd0)) |=> out_mask[0]);

    p_lane0_overlap_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ((opa[63:0] & opb[63:0]) != 64'd0)) |=> !out_mask[0]);
endmodule

bind vtn_mask_unit vtn_mask_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .len_sel   (len_sel),
    .mask_en   (mask_en),
    .wmask     (wmask),
    .bcast     (bcast),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .out_mask  (out_mask)
);

// File: tb/vtn_mask_unit_tb_top.sv
module vtn_mask_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   len_sel;
    logic         mask_en;
    logic [7:0]   wmask;
    logic         bcast;
    logic [511:0] opa;
    logic [511:0] opb;
    logic         out_valid;
    logic [7:0]   out_mask;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] mask;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    logic [7:0] last_mask = 8'h00;

    always #5 clk = ~clk;

    vtn_mask_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .len_sel(len_sel),
        .mask_en(mask_en), .wmask(wmask), .bcast(bcast), .opa(opa),
        .opb(opb), .out_valid(out_valid), .out_mask(out_mask)
    );

    function automatic logic [7:0] expect_mask(
        input logic [1:0] ls, input logic me, input logic [7:0] wm,
        input logic bc, input logic [511:0] a, input logic [511:0] b);
        int n;
        logic [7:0] r;
        logic [63:0] bl;
        n = (ls == 2'b00) ? 2 : (ls == 2'b01) ? 4 : (ls == 2'b10) ? 8 : 0;
        r = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bl = bc ? b[63:0] : b[i*64 +: 64];
            if (i < n && (!me || wm[i]))
                r[i] = ((a[i*64 +: 64] & bl) == 64'd0);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [1:0] ls, input logic me,
                         input logic [7:0] wm, input logic bc,
                         input logic [511:0] a, input logic [511:0] b);
        exp_item_t it;
        @(negedge clk);
        in_valid = 1'b1; len_sel = ls; mask_en = me; wmask = wm;
        bcast = bc; opa = a; opb = b;
        it.mask = expect_mask(ls, me, wm, bc, a, b);
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opa = {16{32'hdead_beef}};
            opb = {16{32'hffff_ffff}};
            wmask = 8'h00;
        end
    endtask

    // Build operands where lane i's AND is zero when zpat[i] is 1.
    task automatic make_ops(input logic [7:0] zpat, output logic [511:0] a,
                            output logic [511:0] b);
        logic [63:0] x;
        for (int i = 0; i < 8; i++) begin
            x = {$urandom, $urandom} | 64'h1;
            a[i*64 +: 64] = x;
            b[i*64 +: 64] = zpat[i] ? ~x : (~x | 64'h1);
        end
    endtask

    // Monitor: sample one unit after each rising edge.
    always @(posedge clk) begin
        logic iv_s, rst_s;
        exp_item_t it;
        iv_s  = in_valid;
        rst_s = rst;
        #1;
        if (!rst_s) begin
            check("R8 out_valid", {7'd0, out_valid}, {7'd0, iv_s});
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check("R8 unexpected result", 8'h01, 8'h00);
                end else begin
                    it = sb_q.pop_front();
                    check(it.tag, out_mask, it.mask);
                    last_mask = it.mask;
                end
            end else begin
                check("R9 hold", out_mask, last_mask);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [511:0] a, b;
        rst = 1'b1; in_valid = 1'b0; len_sel = 2'b10; mask_en = 1'b0;
        wmask = 8'h00; bcast = 1'b0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        check("R10 reset out_valid", {7'd0, out_valid}, 8'h00);
        check("R10 reset out_mask", out_mask, 8'h00);
        rst = 1'b0;
        idle(2);

        // R1: full length, unmasked, assorted zero patterns
        make_ops(8'hff, a, b); drive("R1 all zero", 2'b10, 1'b0, 8'h00, 1'b0, a, b);
        make_ops(8'h00, a, b); drive("R1 all overlap", 2'b10, 1'b0, 8'h00, 1'b0, a, b);
        make_ops(8'ha5, a, b); drive("R1 pattern a5", 2'b10, 1'b0, 8'h00, 1'b0, a, b);
        idle(2);
        drive("R1 zero operands", 2'b10, 1'b0, 8'h00, 1'b0, '0, '1);
        idle(1);

        // R2 masked form, R3 wmask ignored when unmasked
        make_ops(8'hff, a, b); drive("R2 masked 3c", 2'b10, 1'b1, 8'h3c, 1'b0, a, b);
        make_ops(8'hff, a, b); drive("R2 masked none", 2'b10, 1'b1, 8'h00, 1'b0, a, b);
        make_ops(8'hff, a, b); drive("R3 wmask ignored", 2'b10, 1'b0, 8'h00, 1'b0, a, b);
        idle(1);

        // R4 lengths with R7 garbage in upper lanes
        make_ops(8'hff, a, b); drive("R4 len128", 2'b00, 1'b0, 8'h00, 1'b0, a, b);
        make_ops(8'hff, a, b); drive("R4 len256", 2'b01, 1'b0, 8'h00, 1'b0, a, b);
        a = {448'd0, 64'h0}; b = '1;
        a[511:128] = '1;
        drive("R7 upper lanes overlap len128", 2'b00, 1'b0, 8'h00, 1'b0, a, b);
        a[511:256] = '0; a[255:128] = '1;
        drive("R7 upper zero len128", 2'b00, 1'b1, 8'hff, 1'b0, a, b);
        idle(1);

        // R5 reserved length
        make_ops(8'hff, a, b); drive("R5 reserved", 2'b11, 1'b0, 8'h00, 1'b0, a, b);
        idle(1);

        // R6 broadcast: low opb lane everywhere, upper opb ignored
        a = '0; b = '1;
        for (int i = 0; i < 8; i++) a[i*64 +: 64] = (i % 2 == 0) ? 64'h00ff : 64'hff00;
        b[63:0] = 64'h00ff_0000_0000_ff00;
        drive("R6 broadcast", 2'b10, 1'b0, 8'h00, 1'b1, a, b);
        drive("R6 no broadcast", 2'b10, 1'b0, 8'h00, 1'b0, a, b);
        idle(3);

        // R8 back-to-back random mix
        for (int k = 0; k < 40; k++) begin
            make_ops(8'($urandom), a, b);
            drive("R8 random stream", 2'($urandom), 1'($urandom), 8'($urandom),
                  1'($urandom), a, b);
            if (k % 7 == 0) idle(1);
        end
        idle(4);

        // R10 reset mid-stream
        make_ops(8'hff, a, b); drive("R10 before reset", 2'b10, 1'b0, 8'h00, 1'b0, a, b);
        idle(2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R10 reset clears mask", out_mask, 8'h00);
        check("R10 reset clears valid", {7'd0, out_valid}, 8'h00);
        last_mask = 8'h00;
        idle(3);

        check("R8 queue drained", 8'(sb_q.size()), 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule